// File: doc/BRIEF.md
# OTP Protection Register Bank

This block holds a set of one-time-programmable protection registers that are reached as 16-bit words through a plain request/response port. The set has a factory unique identifier, a 64-bit user register, sixteen 128-bit user registers, and two lock words. Each request names one word address. A read returns the word. A program request ANDs the supplied data into the word, so bits can only move from 1 to 0.

Every user register has its own lock bit. The lock bits follow the same one-way rule as the data. After a lock bit is cleared, program requests to that register leave its contents as they are and return a protection error. The lock bit of the unique identifier is already clear when the block leaves reset, and nothing can set it again, so the identifier can never be changed.

Each request gets one registered response in the next cycle. The response carries the resulting word and two error flags. Storage is behavioural, and reset brings it back to its initial contents.

Top module: `otp_prot_bank`

## Requirements
- R1: The word address map is as follows. 0x00 to 0x03 hold the unique identifier, lowest word first. 0x04 to 0x07 hold the user 64-bit register. Wide register n sits at 0x08+8n to 0x0F+8n. 0x88 is lock word A: bit 0 locks the identifier, bit 1 locks the user 64-bit register, and the other bits read as 1. 0x89 is lock word B: bit n locks wide register n. A lock bit of 1 means unlocked.
- R2: A request that is valid in cycle t gives rspValid high in cycle t+1. No request gives no response.
- R3: A permitted program request stores old AND data, so a bit that is 0 never returns to 1. The response carries the stored result.
- R4: The identifier words always read the UNIQUE_ID parameter. A program request to any of them leaves them unchanged and sets rspProtErr.
- R5: While lock word A bit 1 is 1, the user 64-bit register is programmable. Once that bit is cleared, program requests to it leave its data unchanged and set rspProtErr.
- R6: Wide register n is locked by lock word B bit n alone. Locking one wide register leaves every other wide register programmable.
- R7: Lock bits can only be cleared. Programming a 1 into a cleared lock bit has no effect. Lock word A bit 0 stays 0. The lock words themselves are always programmable.
- R8: A request to an address above 0x89 sets rspAddrErr, returns 0xFFFF and changes no state.
- R9: Reads of locked registers return their contents with no error. rspProtErr is set only by a program request to a locked register.
- R10: During reset rspValid and rspData are 0. After reset every user data word reads 0xFFFF, lock word A reads 0xFFFE and lock word B reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = program, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqData | input | WORD_W | Program data (AND mask) |
| rspValid | output | 1 | Response present |
| rspData | output | WORD_W | Word after the request |
| rspProtErr | output | 1 | Program request hit a locked register |
| rspAddrErr | output | 1 | Address outside the map |

## Verification
The data word and both error flags are registered once, so each of them is due exactly one cycle after the edge that takes the request. The bench drives each request on a falling edge and then lets one rising edge take it. It samples on the falling edge that follows, and by then the response from that edge has settled. After that sample it drops reqValid. Checks of state that a rejected or out-of-range request could have touched are made by reading that state back in a later request.

// File: rtl/otp_bank_pkg.sv
package otp_bank_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_UID,
    RG_USER,
    RG_WIDE,
    RG_LOCKA,
    RG_LOCKB
  } region_e;

  typedef struct packed {
    logic    take;
    logic    progUser;
    logic    progLockA;
    logic    progLockB;
    region_e region;
  } strobe_t;

endpackage

// File: rtl/otp_bank_ctrl.sv
module otp_bank_ctrl
  import otp_bank_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int HALF_WORDS = 4,
  parameter int WIDE_REGS  = 16,
  parameter int WIDE_WORDS = 8,
  localparam int USER_WORDS = HALF_WORDS + WIDE_REGS * WIDE_WORDS,
  localparam int IDX_W      = $clog2(USER_WORDS),
  localparam int HW_W       = $clog2(HALF_WORDS),
  localparam int REG_IDX_W  = $clog2(WIDE_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           lockA,
  input  logic [WIDE_REGS-1:0] lockB,
  output strobe_t              strb,
  output logic [IDX_W-1:0]     memIdx,
  output logic [HW_W-1:0]      uidIdx,
  output logic                 rspValid,
  output logic                 rspProtErr,
  output logic                 rspAddrErr
);

  localparam int WW_W = $clog2(WIDE_WORDS);
  localparam logic [ADDR_W-1:0] A_USER  = ADDR_W'(HALF_WORDS);
  localparam logic [ADDR_W-1:0] A_WIDE  = ADDR_W'(2 * HALF_WORDS);
  localparam logic [ADDR_W-1:0] A_LOCKA = ADDR_W'(2 * HALF_WORDS + WIDE_REGS * WIDE_WORDS);
  localparam logic [ADDR_W-1:0] A_LOCKB = ADDR_W'(2 * HALF_WORDS + WIDE_REGS * WIDE_WORDS + 1);

  region_e               region;
  logic [ADDR_W-1:0]     memOff;
  logic [ADDR_W-1:0]     wideOff;
  logic [REG_IDX_W-1:0]  wideSel;
  logic                  lockOpen;
  logic                  dataRegion;
  logic                  wrReq;

  always_comb begin
    if (reqAddr < A_USER)        region = RG_UID;
    else if (reqAddr < A_WIDE)   region = RG_USER;
    else if (reqAddr < A_LOCKA)  region = RG_WIDE;
    else if (reqAddr == A_LOCKA) region = RG_LOCKA;
    else if (reqAddr == A_LOCKB) region = RG_LOCKB;
    else                         region = RG_NONE;
  end

  assign memOff  = reqAddr - A_USER;
  assign wideOff = reqAddr - A_WIDE;
  assign wideSel = REG_IDX_W'(wideOff >> WW_W);
  assign memIdx  = IDX_W'(memOff);
  assign uidIdx  = HW_W'(reqAddr);

  always_comb begin
    case (region)
      RG_UID:  lockOpen = lockA[0];
      RG_USER: lockOpen = lockA[1];
      RG_WIDE: lockOpen = lockB[wideSel];
      default: lockOpen = 1'b1;
    endcase
  end

  assign dataRegion = (region == RG_UID) || (region == RG_USER) || (region == RG_WIDE);
  assign wrReq      = reqValid && reqWrite;

  always_comb begin
    strb.take      = reqValid;
    strb.region    = region;
    strb.progUser  = wrReq && lockOpen && ((region == RG_USER) || (region == RG_WIDE));
    strb.progLockA = wrReq && (region == RG_LOCKA);
    strb.progLockB = wrReq && (region == RG_LOCKB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspProtErr <= 1'b0;
      rspAddrErr <= 1'b0;
    end else begin
      rspValid   <= reqValid;
      rspProtErr <= wrReq && dataRegion && !lockOpen;
      rspAddrErr <= reqValid && (region == RG_NONE);
    end
  end

  // R2
  req_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R4
  uid_write_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && region == RG_UID) |=> rspProtErr);

  // R9
  read_no_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> !rspProtErr);

endmodule

// File: rtl/otp_bank_datapath.sv
module otp_bank_datapath
  import otp_bank_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int HALF_WORDS = 4,
  parameter int WIDE_REGS  = 16,
  parameter int WIDE_WORDS = 8,
  parameter logic [HALF_WORDS*WORD_W-1:0] UNIQUE_ID = '0,
  localparam int USER_WORDS = HALF_WORDS + WIDE_REGS * WIDE_WORDS,
  localparam int IDX_W      = $clog2(USER_WORDS),
  localparam int HW_W       = $clog2(HALF_WORDS),
  localparam int REG_IDX_W  = $clog2(WIDE_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [IDX_W-1:0]     memIdx,
  input  logic [HW_W-1:0]      uidIdx,
  input  logic [WORD_W-1:0]    wrData,
  output logic [1:0]           lockA,
  output logic [WIDE_REGS-1:0] lockB,
  output logic [WORD_W-1:0]    rspData
);

  localparam int WW_W = $clog2(WIDE_WORDS);

  logic [WORD_W-1:0] userMem [USER_WORDS];
  logic [WORD_W-1:0] uidWords [HALF_WORDS];
  logic [WORD_W-1:0] readWord;
  logic [WORD_W-1:0] progWord;
  logic [WORD_W-1:0] lockAWord;
  logic [WORD_W-1:0] lockBWord;
  logic              anyProg;

  for (genvar g = 0; g < HALF_WORDS; g++) begin : g_uid
    assign uidWords[g] = UNIQUE_ID[g*WORD_W +: WORD_W];
  end

  always_comb begin
    lockAWord      = '1;
    lockAWord[1:0] = lockA;
    lockBWord      = '1;
    lockBWord[WIDE_REGS-1:0] = lockB;
  end

  always_comb begin
    case (strb.region)
      RG_UID:          readWord = uidWords[uidIdx];
      RG_USER, RG_WIDE: readWord = userMem[memIdx];
      RG_LOCKA:        readWord = lockAWord;
      RG_LOCKB:        readWord = lockBWord;
      default:         readWord = '1;
    endcase
  end

  assign progWord = readWord & wrData;
  assign anyProg  = strb.progUser || strb.progLockA || strb.progLockB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0;
      lockA   <= 2'b10;
      lockB   <= '1;
      for (int i = 0; i < USER_WORDS; i++) userMem[i] <= '1;
    end else begin
      if (strb.take) rspData <= anyProg ? progWord : readWord;
      if (strb.progUser)  userMem[memIdx] <= progWord;
      if (strb.progLockA) lockA <= lockA & wrData[1:0];
      if (strb.progLockB) lockB <= lockB & wrData[WIDE_REGS-1:0];
    end
  end

  logic [IDX_W-1:0]     wOff;
  logic [REG_IDX_W-1:0] wSel;
  assign wOff = memIdx - IDX_W'(HALF_WORDS);
  assign wSel = REG_IDX_W'(wOff >> WW_W);

  // R7
  lock_oneway_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((lockB & ~$past(lockB)) == '0) && ((lockA & ~$past(lockA)) == 2'b00)));

  // R7
  uid_lock_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockA[0]);

  // R5
  user_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.progUser && strb.region == RG_USER) |-> lockA[1]);

  // R6
  wide_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.progUser && strb.region == RG_WIDE) |-> lockB[wSel]);

  // R3
  mem_clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.progUser |=> ((userMem[$past(memIdx)] & ~$past(readWord)) == '0));

endmodule

// File: rtl/otp_prot_bank.sv
module otp_prot_bank
  import otp_bank_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 8,
  parameter int HALF_WORDS = 4,
  parameter int WIDE_REGS  = 16,
  parameter int WIDE_WORDS = 8,
  parameter logic [HALF_WORDS*WORD_W-1:0] UNIQUE_ID = 64'h1234_5678_9ABC_DEF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqData,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic              rspProtErr,
  output logic              rspAddrErr
);

  localparam int USER_WORDS = HALF_WORDS + WIDE_REGS * WIDE_WORDS;
  localparam int IDX_W      = $clog2(USER_WORDS);
  localparam int HW_W       = $clog2(HALF_WORDS);

  strobe_t              strb;
  logic [IDX_W-1:0]     memIdx;
  logic [HW_W-1:0]      uidIdx;
  logic [1:0]           lockA;
  logic [WIDE_REGS-1:0] lockB;

  otp_bank_ctrl #(
    .ADDR_W(ADDR_W), .HALF_WORDS(HALF_WORDS),
    .WIDE_REGS(WIDE_REGS), .WIDE_WORDS(WIDE_WORDS)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .lockA(lockA), .lockB(lockB),
    .strb(strb), .memIdx(memIdx), .uidIdx(uidIdx),
    .rspValid(rspValid), .rspProtErr(rspProtErr), .rspAddrErr(rspAddrErr)
  );

  otp_bank_datapath #(
    .WORD_W(WORD_W), .HALF_WORDS(HALF_WORDS),
    .WIDE_REGS(WIDE_REGS), .WIDE_WORDS(WIDE_WORDS), .UNIQUE_ID(UNIQUE_ID)
  ) uData (
    .clk(clk), .rstN(rstN),
    .strb(strb), .memIdx(memIdx), .uidIdx(uidIdx), .wrData(reqData),
    .lockA(lockA), .lockB(lockB), .rspData(rspData)
  );

endmodule

// File: tb/sim_otp_prot_bank.sv
module sim_otp_prot_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [15:0] reqData = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        rspProtErr;
  logic        rspAddrErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  otp_prot_bank #(.UNIQUE_ID(64'h1234_5678_9ABC_DEF0)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .rspValid(rspValid),
    .rspData(rspData), .rspProtErr(rspProtErr), .rspAddrErr(rspAddrErr)
  );

  // {write, addr, data, expected word, prot, addrErr, tag}
  localparam int NV = 26;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 8'h00, 16'h0000, 16'hDEF0, 1'b0, 1'b0, 4'd4},  // R4 identifier read
    {1'b1, 8'h00, 16'h0000, 16'hDEF0, 1'b1, 1'b0, 4'd4},  // R4 identifier write rejected
    {1'b0, 8'h03, 16'h0000, 16'h1234, 1'b0, 1'b0, 4'd1},  // R1 top identifier word
    {1'b0, 8'h88, 16'h0000, 16'hFFFE, 1'b0, 1'b0, 4'd10}, // R10 lock word A
    {1'b0, 8'h89, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 4'd10}, // R10 lock word B
    {1'b0, 8'h50, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 4'd10}, // R10 erased data
    {1'b1, 8'h04, 16'hF0F0, 16'hF0F0, 1'b0, 1'b0, 4'd3},  // R3
    {1'b1, 8'h04, 16'hFF00, 16'hF000, 1'b0, 1'b0, 4'd3},  // R3 AND
    {1'b1, 8'h04, 16'hFFFF, 16'hF000, 1'b0, 1'b0, 4'd3},  // R3 no restore
    {1'b1, 8'h08, 16'h1234, 16'h1234, 1'b0, 1'b0, 4'd6},  // R6
    {1'b1, 8'h87, 16'hABCD, 16'hABCD, 1'b0, 1'b0, 4'd1},  // R1 last wide word
    {1'b1, 8'h89, 16'hFFFE, 16'hFFFE, 1'b0, 1'b0, 4'd6},  // R6 lock wide reg 0
    {1'b1, 8'h08, 16'h0000, 16'h1234, 1'b1, 1'b0, 4'd6},  // R6 rejected
    {1'b0, 8'h08, 16'h0000, 16'h1234, 1'b0, 1'b0, 4'd9},  // R9 locked read
    {1'b1, 8'h0F, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 4'd6},  // R6 top word of reg 0
    {1'b1, 8'h10, 16'h00FF, 16'h00FF, 1'b0, 1'b0, 4'd6},  // R6 reg 1 still open
    {1'b1, 8'h89, 16'hFFFF, 16'hFFFE, 1'b0, 1'b0, 4'd7},  // R7
    {1'b1, 8'h88, 16'hFFFD, 16'hFFFC, 1'b0, 1'b0, 4'd5},  // R5 lock user half
    {1'b1, 8'h04, 16'h0000, 16'hF000, 1'b1, 1'b0, 4'd5},  // R5 rejected
    {1'b1, 8'h07, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 4'd5},  // R5 rejected
    {1'b1, 8'h88, 16'hFFFF, 16'hFFFC, 1'b0, 1'b0, 4'd7},  // R7 bit 0 held
    {1'b0, 8'h8A, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 4'd8},  // R8
    {1'b1, 8'hFF, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 4'd8},  // R8
    {1'b0, 8'h04, 16'h0000, 16'hF000, 1'b0, 1'b0, 4'd9},  // R9
    {1'b0, 8'h87, 16'h0000, 16'hABCD, 1'b0, 1'b0, 4'd1},  // R1
    {1'b0, 8'h89, 16'h0000, 16'hFFFE, 1'b0, 1'b0, 4'd8}   // R8 no state change
  };

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic doReq(input bit w, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = w;
    reqAddr  = a;
    reqData  = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 outputs during reset
    check(rspValid == 1'b0, "R10 rspValid in reset", 32'(rspValid), 0);
    check(rspData == 16'h0, "R10 rspData in reset", 32'(rspData), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 no request, no response
    check(rspValid == 1'b0, "R2 idle rspValid", 32'(rspValid), 0);

    for (int i = 0; i < NV; i++) begin
      doReq(VEC[i][46], VEC[i][45:38], VEC[i][37:22]);
      checks++;
      if (rspValid !== 1'b1 || rspData !== VEC[i][21:6] ||
          rspProtErr !== VEC[i][5] || rspAddrErr !== VEC[i][4]) begin
        errors++;
        $display("FAIL vector %0d (R%0d) actual=%b/%h/%b/%b expected=1/%h/%b/%b",
                 i, VEC[i][3:0], rspValid, rspData, rspProtErr, rspAddrErr,
                 VEC[i][21:6], VEC[i][5], VEC[i][4]);
      end
    end

    // R2 response drops one cycle after the request goes away
    @(negedge clk);
    check(rspValid == 1'b0, "R2 response ends", 32'(rspValid), 0);

    // R2 back-to-back requests, one response per cycle
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 8'h01;
    @(negedge clk);
    check(rspValid && rspData == 16'h9ABC, "R2 back-to-back first", 32'(rspData), 32'h9ABC);
    reqAddr = 8'h02;
    @(negedge clk);
    check(rspValid && rspData == 16'h5678, "R2 back-to-back second", 32'(rspData), 32'h5678);
    reqValid = 1'b0;
    @(negedge clk);
    check(rspValid == 1'b0, "R2 back-to-back end", 32'(rspValid), 0);

    // R10 reset restores the initial contents
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doReq(1'b0, 8'h08, 16'h0);
    check(rspData == 16'hFFFF, "R10 data after reset", 32'(rspData), 32'hFFFF);
    doReq(1'b0, 8'h89, 16'h0);
    check(rspData == 16'hFFFF, "R10 lock B after reset", 32'(rspData), 32'hFFFF);
    doReq(1'b0, 8'h88, 16'h0);
    check(rspData == 16'hFFFE, "R10 lock A after reset", 32'(rspData), 32'hFFFE);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule